// File: doc/BRIEF.md
# Conversion-Cycle Sequencer

This block is the digital control of a delta-sigma converter, modelled at cycle level. It steps through three states: converting, sleeping with a finished result, and shifting the result out. It times each conversion as a fixed number of conversion-clock ticks. The ticks come from an internal timebase whose rate follows the rejection select (50 Hz or 60 Hz line notch). When a fast enough clock is present on the shared select pin, the ticks come from that external clock instead.

The end-of-conversion flag is high while a conversion runs. It drops when the tick count completes. If the conversion clock source or the rejection setting changes while a conversion is in progress, only that result is marked as corrupted. The mark clears when the next conversion starts. The same changes have no effect while the block is sleeping or shifting data out.

All three pins are asynchronous to the system clock. Each passes through a two-stage synchronizer before use. The filter and modulator arithmetic are outside this block.

Top module: `conv_sequencer`

## Requirements
- R1: After reset, `state_o` reads 0 (converting), `eoc_o` is 1 and `result_bad_o` is 0. The state encoding is 0 = converting, 1 = sleeping, 2 = shifting out.
- R2: Without an external clock, one tick occurs every `INT_DIV_60` system clocks while the synchronized select pin is low, and every `INT_DIV_50` system clocks while it is high. A conversion ends on its `CONV_TICKS`-th tick. From reset release with the pin held low, the sleeping state is first visible `2 + INT_DIV_60*CONV_TICKS` cycles later.
- R3: The external clock is taken as present when two rising edges of the select pin fall fewer than `DET_LIMIT` system clocks apart. While it is present, each rising edge is one tick.
- R4: When no rising edge arrives for `DET_LIMIT` system clocks, the block falls back to the internal timebase. A slower clock is never used as the tick source.
- R5: `eoc_o` is high throughout a conversion. It goes low in the same cycle that the state becomes sleeping.
- R6: The block stays asleep while chip select (`cs_n`) is high, whatever SCK does. It moves to shifting out on an SCK rising edge seen while chip select is low.
- R7: Shifting out ends on the `FRAME_BITS`-th SCK falling edge. A new conversion then starts with `eoc_o` high.
- R8: Raising chip select while shifting out starts a new conversion at once.
- R9: A change of clock source or rejection select during a conversion sets `result_bad_o`. The flag holds until the next conversion starts, where it clears.
- R10: Clock-source or rejection changes while sleeping or shifting out leave `result_bad_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| fo_pin | input | 1 | Rejection select level (high = 50 Hz) or external conversion clock |
| state_o | output | 2 | Sequencer state: 0 converting, 1 sleeping, 2 shifting out |
| eoc_o | output | 1 | End-of-conversion flag, high while converting |
| result_bad_o | output | 1 | Current or last conversion result is untrustworthy |

## Verification
A configuration change on the select pin can be detected in the same cycle as the final tick of a conversion. In that cycle the corrupted flag must be set while the state moves to sleeping. The bench repeats conversions and flips the select pin at a sweep of offsets near the expected end, so that one offset lands on the completion tick. A behavioural reference model judges every cycle, and it requires the flag and the sleeping state to appear together. A second overlap occurs when a chip-select release and the last SCK falling edge arrive close together. In that case the frame end must be taken first.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

  typedef enum logic [1:0] {
    ST_CONVERT  = 2'd0,
    ST_SLEEP    = 2'd1,
    ST_DATA_OUT = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic ext_src;
    logic sel_50;
  } clk_cfg_t;

endpackage

// File: rtl/cseq_reset_sync.sv
module cseq_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_sync_n = stg_q[1];

endmodule

// File: rtl/cseq_pin_sync.sv
module cseq_pin_sync #(
  parameter int               WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] lvl_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [1:0] ff_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff_q <= {2{RST_VAL[i]}};
      else        ff_q <= {ff_q[0], pin_i[i]};
    end
    assign lvl_o[i] = ff_q[1];
  end

endmodule

// File: rtl/cseq_clk_source.sv
module cseq_clk_source
  import cseq_pkg::*;
#(
  parameter int DIV_60    = 814,
  parameter int DIV_50    = 977,
  parameter int DET_LIMIT = 48828
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fo_lvl,
  output logic tick_o,
  output logic cfg_chg_o
);

  localparam int DIV_MAX = (DIV_60 > DIV_50) ? DIV_60 : DIV_50;
  localparam int DIV_W   = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;
  localparam int GAP_W   = $clog2(DET_LIMIT + 1);
  localparam logic [DIV_W-1:0] LIM_60  = DIV_W'(DIV_60 - 1);
  localparam logic [DIV_W-1:0] LIM_50  = DIV_W'(DIV_50 - 1);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(DET_LIMIT);

  logic             fo_prev_q;
  logic             ext_q, ext_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             gap_en;
  logic [DIV_W-1:0] div_q, div_d;
  clk_cfg_t         cfg_q, cfg_now;
  logic             fo_rise;
  logic [DIV_W-1:0] div_lim;
  logic             tick_int;

  // Tick selection and configuration tracking
  always_comb begin
    fo_rise          = fo_lvl & ~fo_prev_q;
    div_lim          = fo_lvl ? LIM_50 : LIM_60;
    tick_int         = (div_q >= div_lim);
    tick_o           = ext_q ? fo_rise : tick_int;
    cfg_now.ext_src  = ext_q;
    cfg_now.sel_50   = ~ext_q & fo_lvl;
    cfg_chg_o        = (cfg_now != cfg_q);
  end

  // Next-state: edge-gap detector and internal divider
  always_comb begin
    ext_d  = ext_q;
    gap_d  = gap_q;
    gap_en = 1'b0;
    if (fo_rise) begin
      gap_en = 1'b1;
      gap_d  = '0;
      ext_d  = (gap_q < GAP_MAX);
    end else if (gap_q < GAP_MAX) begin
      gap_en = 1'b1;
      gap_d  = gap_q + 1'b1;
    end else begin
      ext_d  = 1'b0;
    end
    if (ext_q || tick_int) div_d = '0;
    else                   div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fo_prev_q <= 1'b0;
      ext_q     <= 1'b0;
      gap_q     <= GAP_MAX;
      div_q     <= '0;
      cfg_q     <= '0;
    end else begin
      fo_prev_q <= fo_lvl;
      ext_q     <= ext_d;
      if (gap_en) gap_q <= gap_d;
      div_q     <= div_d;
      cfg_q     <= cfg_now;
    end
  end

  AST_EXT_ACQUIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (fo_rise && gap_q < GAP_MAX) |=> ext_q); // R3
  AST_EXT_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!fo_rise && gap_q == GAP_MAX) |=> !ext_q); // R4
  AST_INT_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_q && tick_o) |=> !tick_o); // R2

endmodule

// File: rtl/cseq_fsm.sv
module cseq_fsm
  import cseq_pkg::*;
#(
  parameter int CONV_TICKS = 20480,
  parameter int FRAME_BITS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       cfg_chg_i,
  input  logic       cs_lvl_i,
  input  logic       sck_lvl_i,
  output seq_state_e state_o,
  output logic       eoc_o,
  output logic       bad_o
);

  localparam int CNT_W = $clog2(CONV_TICKS);
  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_TICKS - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

  seq_state_e       st_q, st_d;
  logic             eoc_q, eoc_d;
  logic             bad_q, bad_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             cnt_en, bit_en;
  logic             sck_prev_q;
  logic             sck_rise, sck_fall;
  logic             start_conv;

  assign sck_rise = sck_lvl_i & ~sck_prev_q;
  assign sck_fall = ~sck_lvl_i & sck_prev_q;

  always_comb begin
    st_d       = st_q;
    eoc_d      = eoc_q;
    bad_d      = bad_q;
    cnt_d      = cnt_q;
    bit_d      = bit_q;
    cnt_en     = 1'b0;
    bit_en     = 1'b0;
    start_conv = 1'b0;
    case (st_q)
      ST_CONVERT: begin
        if (cfg_chg_i) bad_d = 1'b1;
        if (tick_i) begin
          cnt_en = 1'b1;
          if (cnt_q == CNT_LAST) begin
            st_d  = ST_SLEEP;
            eoc_d = 1'b0;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_SLEEP: begin
        if (!cs_lvl_i && sck_rise) begin
          st_d   = ST_DATA_OUT;
          bit_en = 1'b1;
          bit_d  = '0;
        end
      end
      ST_DATA_OUT: begin
        if (cs_lvl_i) begin
          start_conv = 1'b1;
        end else if (sck_fall) begin
          if (bit_q == BIT_LAST) begin
            start_conv = 1'b1;
          end else begin
            bit_en = 1'b1;
            bit_d  = bit_q + 1'b1;
          end
        end
      end
      default: start_conv = 1'b1;
    endcase
    if (start_conv) begin
      st_d   = ST_CONVERT;
      eoc_d  = 1'b1;
      bad_d  = 1'b0;
      cnt_en = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_CONVERT;
      eoc_q      <= 1'b1;
      bad_q      <= 1'b0;
      cnt_q      <= '0;
      bit_q      <= '0;
      sck_prev_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      eoc_q      <= eoc_d;
      bad_q      <= bad_d;
      sck_prev_q <= sck_lvl_i;
      if (cnt_en) cnt_q <= cnt_d;
      if (bit_en) bit_q <= bit_d;
    end
  end

  assign state_o = st_q;
  assign eoc_o   = eoc_q;
  assign bad_o   = bad_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST); // R2
  AST_EOC_FALL_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eoc_q) |-> st_q == ST_SLEEP); // R5
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SLEEP && cs_lvl_i) |=> st_q == ST_SLEEP); // R6
  AST_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA_OUT && !cs_lvl_i && sck_fall && bit_q == BIT_LAST)
      |=> (st_q == ST_CONVERT && eoc_q)); // R7
  AST_CS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA_OUT && cs_lvl_i) |=> st_q == ST_CONVERT); // R8
  AST_BAD_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CONVERT && cfg_chg_i) |=> bad_q); // R9
  AST_BAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_CONVERT) |=> ($stable(bad_q) || (st_q == ST_CONVERT && !bad_q))); // R10

endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import cseq_pkg::*;
#(
  parameter int CONV_TICKS = 20480,
  parameter int INT_DIV_60 = 814,
  parameter int INT_DIV_50 = 977,
  parameter int DET_LIMIT  = 48828,
  parameter int FRAME_BITS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       fo_pin,
  output logic [1:0] state_o,
  output logic       eoc_o,
  output logic       result_bad_o
);

  localparam int PIN_W = 3;
  localparam logic [PIN_W-1:0] PIN_RST = 3'b100;

  logic             rst_i;
  logic [PIN_W-1:0] pin_lvl;
  logic             tick;
  logic             cfg_chg;
  seq_state_e       st;

  cseq_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i)
  );

  cseq_pin_sync #(
    .WIDTH   (PIN_W),
    .RST_VAL (PIN_RST)
  ) u_pins (
    .clk   (clk),
    .rst_n (rst_i),
    .pin_i ({cs_n, sck, fo_pin}),
    .lvl_o (pin_lvl)
  );

  cseq_clk_source #(
    .DIV_60    (INT_DIV_60),
    .DIV_50    (INT_DIV_50),
    .DET_LIMIT (DET_LIMIT)
  ) u_src (
    .clk       (clk),
    .rst_n     (rst_i),
    .fo_lvl    (pin_lvl[0]),
    .tick_o    (tick),
    .cfg_chg_o (cfg_chg)
  );

  cseq_fsm #(
    .CONV_TICKS (CONV_TICKS),
    .FRAME_BITS (FRAME_BITS)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_i),
    .tick_i    (tick),
    .cfg_chg_i (cfg_chg),
    .cs_lvl_i  (pin_lvl[2]),
    .sck_lvl_i (pin_lvl[1]),
    .state_o   (st),
    .eoc_o     (eoc_o),
    .bad_o     (result_bad_o)
  );

  assign state_o = st;

endmodule

// File: tb/conv_sequencer_bench.sv
module conv_sequencer_bench;

  localparam int CONV  = 16;
  localparam int D60   = 3;
  localparam int D50   = 5;
  localparam int LIM   = 12;
  localparam int FRAME = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic fo = 1'b0;
  logic [1:0] state_o;
  logic eoc_o, result_bad_o;

  always #4 clk = ~clk;

  conv_sequencer #(
    .CONV_TICKS (CONV), .INT_DIV_60 (D60), .INT_DIV_50 (D50),
    .DET_LIMIT (LIM), .FRAME_BITS (FRAME)
  ) u_conv_sequencer (
    .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .sck (sck), .fo_pin (fo),
    .state_o (state_o), .eoc_o (eoc_o), .result_bad_o (result_bad_o)
  );

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit fin = 0, cmp_en = 0;

  // select-pin driver: level or free-running clock
  bit fo_level = 0, ext_run = 0;
  int ext_half = 2, ext_ph = 0;
  always @(negedge clk) begin
    if (ext_run) begin
      ext_ph++;
      if (ext_ph >= ext_half) begin fo = ~fo; ext_ph = 0; end
    end else begin
      fo = fo_level;
      ext_ph = 0;
    end
  end

  // behavioural reference model
  int m_st, m_eoc, m_bad, m_cnt, m_bit, m_gap, m_ext, m_div, m_cfgp, m_rc;
  int f1, f2, fp, k1, k2, kp, c1, c2;

  task automatic m_reset();
    m_st = 0; m_eoc = 1; m_bad = 0; m_cnt = 0; m_bit = 0;
    m_gap = LIM; m_ext = 0; m_div = 0; m_cfgp = 0;
    f1 = 0; f2 = 0; fp = 0; k1 = 0; k2 = 0; kp = 0; c1 = 1; c2 = 1;
  endtask

  initial begin m_reset(); m_rc = 0; end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reset(); m_rc = 0;
    end else if (m_rc < 2) begin
      m_rc++;
    end else begin
      bit fo_r, k_r, k_f, tint, tick, chg, start;
      int lim, cfg;
      fo_r = (f2 == 1 && fp == 0);
      k_r  = (k2 == 1 && kp == 0);
      k_f  = (k2 == 0 && kp == 1);
      lim  = f2 ? D50 - 1 : D60 - 1;
      tint = (m_div >= lim);
      tick = m_ext ? fo_r : tint;
      cfg  = m_ext ? 2 : f2;
      chg  = (cfg != m_cfgp);
      start = 0;
      case (m_st)
        0: begin
          if (chg) m_bad = 1;
          if (tick) begin
            if (m_cnt == CONV - 1) begin m_st = 1; m_eoc = 0; m_cnt = 0; end
            else m_cnt = m_cnt + 1;
          end
        end
        1: if (c2 == 0 && k_r) begin m_st = 2; m_bit = 0; end
        default: begin
          if (c2 == 1) start = 1;
          else if (k_f) begin
            if (m_bit == FRAME - 1) start = 1;
            else m_bit = m_bit + 1;
          end
        end
      endcase
      if (start) begin m_st = 0; m_eoc = 1; m_bad = 0; m_cnt = 0; end
      m_div = (m_ext || tint) ? 0 : m_div + 1;
      if (fo_r) begin m_ext = (m_gap < LIM); m_gap = 0; end
      else if (m_gap < LIM) m_gap = m_gap + 1;
      else m_ext = 0;
      m_cfgp = cfg;
      fp = f2; f2 = f1; f1 = fo;
      kp = k2; k2 = k1; k1 = sck;
      c2 = c1; c1 = cs_n;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_en) chk({cur_req, " model"}, {state_o, eoc_o, result_bad_o},
                    m_st * 4 + m_eoc * 2 + m_bad);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_state(input int s, input int max, output int n);
    n = 0;
    while (int'(state_o) != s && n < max) begin cyc(1); n++; end
  endtask

  task automatic sck_pulse();
    sck = 1'b1; cyc(2); sck = 1'b0; cyc(2);
  endtask

  task automatic readout();
    cs_n = 1'b0; cyc(3);
    repeat (FRAME) sck_pulse();
    cyc(2); cs_n = 1'b1; cyc(1);
  endtask

  initial begin
    int n;
    #1 rst_n = 1'b0;
    cyc(3);
    rst_n = 1'b1; cmp_en = 1;
    cur_req = "R1";
    chk("R1 state", state_o, 0);
    chk("R1 eoc", eoc_o, 1);
    chk("R1 bad", result_bad_o, 0);

    cur_req = "R2";
    wait_state(1, 400, n);
    chk("R2 internal 60 length", n, 2 + D60 * CONV);
    chk("R5 eoc low in sleep", eoc_o, 0);

    cur_req = "R6";
    repeat (3) sck_pulse();
    chk("R6 sleep with cs high", state_o, 1);
    cs_n = 1'b0; cyc(6);
    chk("R6 sleep without sck", state_o, 1);
    repeat (FRAME - 1) sck_pulse();
    cyc(2);
    cur_req = "R7";
    chk("R7 still shifting", state_o, 2);
    sck_pulse(); cyc(2);
    chk("R7 frame end state", state_o, 0);
    chk("R7 frame end eoc", eoc_o, 1);
    cs_n = 1'b1;

    cur_req = "R10";
    wait_state(1, 400, n);
    fo_level = 1; cyc(6);
    chk("R10 sleep change", result_bad_o, 0);
    cs_n = 1'b0; cyc(3);
    repeat (FRAME / 2) sck_pulse();
    fo_level = 0; cyc(4); fo_level = 1;
    repeat (FRAME / 2) sck_pulse();
    cyc(2); cs_n = 1'b1; cyc(1);
    chk("R10 shift change state", state_o, 0);
    chk("R10 shift change bad", result_bad_o, 0);
    wait_state(1, 400, n);
    chk("R2 50 conversion clean", result_bad_o, 0);

    cur_req = "R9";
    readout();
    cyc(20); fo_level = 0; cyc(5);
    chk("R9 mid change flagged", result_bad_o, 1);
    wait_state(1, 400, n);
    chk("R9 flag held in sleep", result_bad_o, 1);
    readout();
    chk("R9 cleared at new conversion", result_bad_o, 0);
    wait_state(1, 400, n);

    cur_req = "R3";
    ext_half = 2; ext_run = 1; cyc(30);
    readout();
    wait_state(1, 400, n);
    chk("R3 external length", (n >= CONV * 4 - 8 && n <= CONV * 4 + 4) ? 1 : 0, 1);
    chk("R3 clean under external", result_bad_o, 0);

    cur_req = "R4";
    readout();
    cyc(20); ext_run = 0; fo_level = 0;
    wait_state(1, 400, n);
    chk("R4 fallback completes", state_o, 1);
    chk("R4 fallback flagged", result_bad_o, 1);
    ext_half = 8; ext_run = 1; cyc(40);
    readout();
    wait_state(1, 400, n);
    chk("R4 slow clock ignored", (n < 150) ? 1 : 0, 1);
    ext_run = 0; fo_level = 0; cyc(20);

    cur_req = "R8";
    cs_n = 1'b0; cyc(3);
    repeat (5) sck_pulse();
    chk("R8 shifting", state_o, 2);
    cs_n = 1'b1; cyc(4);
    chk("R8 abort to convert", state_o, 0);
    wait_state(1, 400, n);

    cur_req = "R9 sweep";
    for (int off = 0; off < 12; off++) begin
      readout();
      cyc(38 + off);
      fo_level = ~fo_level;
      wait_state(1, 400, n);
      cyc(2);
    end

    fin = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("test done: total=%0d bad=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule